// File: doc/BRIEF.md
# Multi-Mode Serial Bit-Rate Generator

This block produces the timing for one channel of a serial port. Software sets an 8-bit rate value N and a control byte holding a prescaler choice, an operating mode, a fast bit and a card cycle choice. From these the block emits a single-cycle sampling strobe once per basic-clock period and a single-cycle bit strobe once per bit interval. The shifters, framing and line protocol that consume these strobes are outside the block.

Counting runs in three nested stages. A prescaler divides the system clock by 4^n. A rate counter divides that by N+1. A half stage doubles it, so one basic period is 2·4^n·(N+1) system clocks. A bit counter then counts a number of basic periods that depends on the mode: 16 in asynchronous mode, 8 in asynchronous fast mode, 2 in clocked synchronous mode, or a selectable 32, 64, 256 or 372 in smart card mode. Each channel has its own copy of the block, so channels run at independent rates. A register write or a low enable returns every counter to zero.

Top module: `serial_rate_gen`

## Requirements
- R1: Address 0 holds the rate value N and resets to 0xFF. Address 1 holds the control byte and resets to 0x00. Both can be written at any time with cfg_we, and cfg_rdata shows the addressed register combinationally.
- R2: The control byte layout is: bits [1:0] select the prescaler n (divide by 4^n), bits [3:2] select the mode (00 asynchronous, 01 clocked synchronous, 10 or 11 smart card), bit 4 is the asynchronous fast bit, and bits [6:5] select the card count (00→32, 01→64, 10→372, 11→256). Bit 7 always reads 0.
- R3: sample_tick fires once every P = 2·4^n·(N+1) system clocks.
- R4: In asynchronous mode with the fast bit clear, bit_tick fires once every 32·4^n·(N+1) system clocks.
- R5: In asynchronous mode with the fast bit set, bit_tick fires once every 16·4^n·(N+1) system clocks.
- R6: In clocked synchronous mode, bit_tick fires once every 4·4^n·(N+1) system clocks, and the fast bit has no effect.
- R7: In smart card mode, bit_tick fires once every S·2·4^n·(N+1) system clocks, where S is the selected card count.
- R8: Every bit_tick falls in the same cycle as a sample_tick.
- R9: A write to either register clears all counters. Counting the first cycle after the write edge as cycle 1, the first sample_tick comes in cycle P and the first bit_tick comes in the cycle equal to the full bit period.
- R10: While en is low, no strobe fires and the counters are held at zero. Once en rises, the first strobes arrive after full periods, counted as in R9.
- R11: Each strobe is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Count enable; low holds the counters at zero |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 rate, 1 control |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the addressed register |
| sample_tick | output | 1 | One-cycle strobe per basic-clock period |
| bit_tick | output | 1 | One-cycle strobe per bit interval |

## Verification
The bit strobe and the sampling strobe are both produced on the last basic period of a bit, so they must fall in the same cycle. Every configuration swept by the bench drives both strobes through at least two full bit intervals. In each sampled cycle the bench flags any bit strobe that arrives without its sampling strobe, and it checks the positions of both strobes against periods computed from the mode formulas. A register write that lands in the middle of a bit interval is the second collision; the bench judges it by requiring that the next bit strobe comes one full period after the write edge.

// File: rtl/srg_pkg.sv
// Shared types and helpers for the serial rate generator.
// Assumes the control byte layout described in the brief.
package srg_pkg;

    typedef enum logic [1:0] {
        MODE_ASYNC    = 2'b00,
        MODE_SYNC     = 2'b01,
        MODE_CARD     = 2'b10,
        MODE_CARD_ALT = 2'b11
    } srg_mode_e;

    localparam int unsigned BITCNT_W = 9;

    // Number of basic-clock periods that make up one bit interval.
    function automatic logic [BITCNT_W-1:0] basics_per_bit(
        input srg_mode_e  mode,
        input logic       fast,
        input logic [1:0] card_sel
    );
        logic [BITCNT_W-1:0] k;
        case (mode)
            MODE_ASYNC: k = fast ? BITCNT_W'(8) : BITCNT_W'(16);
            MODE_SYNC:  k = BITCNT_W'(2);
            default: begin
                case (card_sel)
                    2'b00:   k = BITCNT_W'(32);
                    2'b01:   k = BITCNT_W'(64);
                    2'b10:   k = BITCNT_W'(372);
                    default: k = BITCNT_W'(256);
                endcase
            end
        endcase
        return k;
    endfunction

endpackage

// File: rtl/srg_regs.sv
// Register pair for the rate generator: rate value and control byte.
// Any write produces a one-cycle restart pulse that clears the counters.
// Assumes one write port; reads are combinational.
module srg_regs
    import srg_pkg::*;
#(
    parameter int unsigned RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic [RATE_W-1:0] rate_n,
    output logic [1:0]        psel,
    output srg_mode_e         mode,
    output logic              fast,
    output logic [1:0]        card_sel,
    output logic              restart
);

    localparam logic [7:0] CTRL_MASK = 8'h7F;

    logic [RATE_W-1:0] rate_q;
    logic [7:0]        ctrl_q;

    // Capture register writes; synchronous reset to the documented values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '1;
            ctrl_q <= '0;
        end else if (cfg_we) begin
            if (cfg_addr) ctrl_q <= cfg_wdata & CTRL_MASK;
            else          rate_q <= cfg_wdata[RATE_W-1:0];
        end
    end

    // Read mux and field split.
    always_comb begin
        cfg_rdata = cfg_addr ? ctrl_q : 8'(rate_q);
        rate_n    = rate_q;
        psel      = ctrl_q[1:0];
        mode      = srg_mode_e'(ctrl_q[3:2]);
        fast      = ctrl_q[4];
        card_sel  = ctrl_q[6:5];
        restart   = cfg_we;
    end

    // R1
    rate_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rate_q == '1 && ctrl_q == 8'h00));
    // R1
    rate_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_addr) |=> (rate_q == $past(cfg_wdata[RATE_W-1:0])));
    // R2
    ctrl_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr) |=> (ctrl_q[7] == 1'b0));

endmodule

// File: rtl/srg_divider.sv
// Basic-clock divider: prescaler by 4^n, rate counter by N+1, then a
// half stage, giving one sample strobe every 2*4^n*(N+1) clocks.
// Assumes psel and rate_n change only together with a clear pulse.
module srg_divider #(
    parameter int unsigned RATE_W = 8,
    parameter int unsigned PSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              en,
    input  logic [RATE_W-1:0] rate_n,
    input  logic [PSEL_W-1:0] psel,
    output logic              basic_tick
);

    localparam int unsigned PRE_W = 2 * ((1 << PSEL_W) - 1);

    logic [PRE_W-1:0]  pre_cnt;
    logic [PRE_W-1:0]  pre_lim;
    logic [PRE_W:0]    pre_span;
    logic [RATE_W-1:0] rate_cnt;
    logic              half_q;
    logic              pre_last;
    logic              rate_last;

    // Prescaler terminal value 4^n - 1 and stage end flags.
    always_comb begin
        pre_span   = (PRE_W+1)'(1) << {psel, 1'b0};
        pre_lim    = PRE_W'(pre_span - 1'b1);
        pre_last   = (pre_cnt == pre_lim);
        rate_last  = (rate_cnt == rate_n);
        basic_tick = en && pre_last && rate_last && half_q;
    end

    // Advance the three stages; reset, clear or disable returns them to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !en) begin
            pre_cnt  <= '0;
            rate_cnt <= '0;
            half_q   <= 1'b0;
        end else begin
            pre_cnt <= pre_last ? '0 : pre_cnt + 1'b1;
            if (pre_last) begin
                if (rate_last) begin
                    rate_cnt <= '0;
                    half_q   <= ~half_q;
                end else begin
                    rate_cnt <= rate_cnt + 1'b1;
                end
            end
        end
    end

    // R11
    basic_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        basic_tick |=> !basic_tick);
    // R9
    basic_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !basic_tick);
    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_cnt <= pre_lim) && (rate_cnt <= rate_n));
    // R10
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pre_cnt == '0 && rate_cnt == '0 && !half_q));

endmodule

// File: rtl/srg_bitcount.sv
// Bit interval counter: counts sample strobes and emits a bit strobe on
// the last basic period of each bit. The count per bit follows the mode.
// Assumes basic_tick is already gated by the enable.
module srg_bitcount
    import srg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       en,
    input  logic       basic_tick,
    input  srg_mode_e  mode,
    input  logic       fast,
    input  logic [1:0] card_sel,
    output logic       bit_tick
);

    logic [BITCNT_W-1:0] bit_cnt;
    logic [BITCNT_W-1:0] bit_lim;

    // Last basic period index for the current mode.
    always_comb begin
        bit_lim  = basics_per_bit(mode, fast, card_sel) - 1'b1;
        bit_tick = basic_tick && (bit_cnt == bit_lim);
    end

    // Count sample strobes within a bit; wrap on the bit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !en) begin
            bit_cnt <= '0;
        end else if (basic_tick) begin
            bit_cnt <= bit_tick ? '0 : bit_cnt + 1'b1;
        end
    end

    // R4
    bit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> (bit_cnt == '0));
    // R7
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= bit_lim);

endmodule

// File: rtl/serial_rate_gen.sv
// Top of the per-channel serial rate generator: registers, basic-clock
// divider and bit interval counter. One instance serves one channel.
// Assumes a single clock domain and synchronous active-low reset.
module serial_rate_gen
    import srg_pkg::*;
#(
    parameter int unsigned RATE_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       cfg_we,
    input  logic       cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    output logic       sample_tick,
    output logic       bit_tick
);

    localparam int unsigned PSEL_W = 2;

    logic [RATE_W-1:0] rate_n;
    logic [PSEL_W-1:0] psel;
    srg_mode_e         mode;
    logic              fast;
    logic [1:0]        card_sel;
    logic              restart;

    srg_regs #(.RATE_W(RATE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .rate_n    (rate_n),
        .psel      (psel),
        .mode      (mode),
        .fast      (fast),
        .card_sel  (card_sel),
        .restart   (restart)
    );

    srg_divider #(.RATE_W(RATE_W), .PSEL_W(PSEL_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (restart),
        .en         (en),
        .rate_n     (rate_n),
        .psel       (psel),
        .basic_tick (sample_tick)
    );

    srg_bitcount u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (restart),
        .en         (en),
        .basic_tick (sample_tick),
        .mode       (mode),
        .fast       (fast),
        .card_sel   (card_sel),
        .bit_tick   (bit_tick)
    );

    // R8
    bit_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);
    // R11
    bit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);
    // R10
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en) |-> !bit_tick);

endmodule

// File: tb/sim_serial_rate_gen.sv
`timescale 1ns/1ps
module sim_serial_rate_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_addr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       sample_tick;
    logic       bit_tick;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    serial_rate_gen u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        cfg_addr  = a;
        cfg_wdata = d;
        cfg_we    = 1'b1;
        @(posedge clk);
        #1 cfg_we = 1'b0;
    endtask

    // Samples span cycles after a restart (cycle 1 = first after the edge).
    task automatic measure(input int p, input int b, input int k,
                           input string req, input int span);
        int first_s = -1;
        int first_b = -1;
        int second_b = -1;
        int ns = 0;
        int nb = 0;
        int orphan = 0;
        for (int c = 1; c <= span; c++) begin
            @(negedge clk);
            if (sample_tick) begin
                ns++;
                if (first_s < 0) first_s = c;
            end
            if (bit_tick) begin
                nb++;
                if (!sample_tick) orphan++;
                if (first_b < 0) first_b = c;
                else if (second_b < 0) second_b = c;
            end
        end
        check(first_s == p, "R3", "first sample strobe cycle", first_s, p);
        check(first_b == b, req, "first bit strobe cycle", first_b, b);
        check(second_b == 2 * b, req, "second bit strobe cycle", second_b, 2 * b);
        check(nb == 2, req, "bit strobes in two intervals", nb, 2);
        check(ns == 2 * k, "R3", "sample strobes in two intervals", ns, 2 * k);
        check(orphan == 0, "R8", "bit strobe without sample strobe", orphan, 0);
    endtask

    function automatic int card_count(input int sel);
        case (sel)
            0: return 32;
            1: return 64;
            2: return 372;
            default: return 256;
        endcase
    endfunction

    // mode: 0 async, 1 sync, 2 smart card
    task automatic run_case(input int mode, input int fast, input int n,
                            input int rate, input int csel, input string req);
        int p;
        int k;
        p = 2 * (4 ** n) * (rate + 1);
        if (mode == 0)      k = fast ? 8 : 16;
        else if (mode == 1) k = 2;
        else                k = card_count(csel);
        cfg_write(1'b0, 8'(rate));
        cfg_write(1'b1, 8'((csel << 5) | (fast << 4) | (mode << 2) | n));
        measure(p, p * k, k, req, 2 * p * k);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        cfg_addr = 1'b0;
        #0.1 check(cfg_rdata == 8'hFF, "R1", "rate reset value", cfg_rdata, 255);
        cfg_addr = 1'b1;
        #0.1 check(cfg_rdata == 8'h00, "R1", "control reset value", cfg_rdata, 0);
        cfg_write(1'b0, 8'h5A);
        cfg_addr = 1'b0;
        #0.1 check(cfg_rdata == 8'h5A, "R1", "rate readback", cfg_rdata, 90);
        cfg_write(1'b1, 8'hFF);
        cfg_addr = 1'b1;
        #0.1 check(cfg_rdata == 8'h7F, "R2", "control top bit reads zero", cfg_rdata, 127);

        // R10: disabled, nothing fires
        cfg_write(1'b0, 8'h00);
        cfg_write(1'b1, 8'h00);
        cnt = 0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (sample_tick || bit_tick) cnt++;
        end
        check(cnt == 0, "R10", "strobes while disabled", cnt, 0);
        @(posedge clk);
        #1 en = 1'b1;
        measure(2, 32, 16, "R10", 64);

        // R4 / R5 asynchronous sweep
        run_case(0, 0, 0, 0,   0, "R4");
        run_case(0, 0, 0, 255, 0, "R4");
        run_case(0, 0, 2, 1,   0, "R4");
        run_case(0, 0, 3, 0,   0, "R4");
        run_case(0, 1, 1, 3,   0, "R5");
        run_case(0, 1, 3, 0,   0, "R5");
        // R6 synchronous, fast bit ignored
        run_case(1, 1, 0, 0,   0, "R6");
        run_case(1, 0, 1, 255, 0, "R6");
        run_case(1, 1, 2, 2,   0, "R6");
        // R7 smart card counts
        run_case(2, 0, 0, 0, 0, "R7");
        run_case(2, 0, 1, 0, 1, "R7");
        run_case(2, 0, 0, 0, 2, "R7");
        run_case(2, 0, 0, 4, 2, "R7");
        run_case(2, 0, 2, 0, 3, "R7");
        run_case(3, 0, 0, 1, 0, "R7");

        // R9: a write in mid interval restarts the bit
        run_case(0, 0, 0, 0, 0, "R9");
        repeat (20) @(negedge clk);
        cfg_write(1'b0, 8'h00);
        measure(2, 32, 16, "R9", 64);

        // R10: dropping enable mid interval clears the counters
        repeat (10) @(negedge clk);
        @(posedge clk);
        #1 en = 1'b0;
        @(posedge clk);
        #1 en = 1'b1;
        measure(2, 32, 16, "R10", 64);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule